// File: doc/BRIEF.md
# Programmable CRC Engine

This block computes a 16-bit or 32-bit cyclic redundancy checksum over a byte stream that a host pushes through a small register port. The host picks the generator polynomial, the starting value, whether each input byte is bit-reversed, whether the result is bit-reversed and whether it is inverted. It can also choose to read the unprocessed remainder instead of the finished checksum. Writing the start value opens a new computation. Each write to the data register carries one to four bytes, and the engine folds them in one per clock, most significant byte first.

The write side follows a valid/ready handshake. A write is taken on a rising edge where `wr_valid` and `wr_ready` are both high. `wr_ready` drops for exactly as many cycles as the accepted data write carried bytes, and no write of any kind is taken in that window. The host keeps `wr_valid`, `wr_addr`, `wr_data` and `wr_nbytes` steady until the write is taken. Reads go through a plain combinational port and are not stalled. A read of the result is only meaningful while `busy` is low.

The register map is fixed: address 0 is control, 1 is the polynomial, 2 is the start value and 3 is data (on a write) or result (on a read). The control bits are: bit 0 selects 32-bit width, bit 1 reverses input bytes, bit 2 reverses the output, bit 3 inverts the output and bit 4 selects raw read-out.

Top module: `crc_engine`

## Requirements
- R1: After reset, control reads 0, the polynomial reads 0x1021, the start value reads 0xFFFF and the result reads 0xFFFF.
- R2: The polynomial is given with its leading coefficient omitted and the highest remaining coefficient in the top bit of the active width. With the reset settings, the nine ASCII bytes "123456789" give 0x29B1.
- R3: A write to address 2 loads the running remainder with the written value, masked to the active width. While no byte is pending and no start value is written, the remainder holds.
- R4: A write to address 3 carries `wr_nbytes`+1 bytes in the low bytes of `wr_data`. They are folded most significant first, one per clock, and `busy` is high for exactly that many cycles. Any chunking of a message gives the same checksum.
- R5: Control bit 0 selects the width (1 = 32-bit). In 16-bit mode only the low 16 bits of the polynomial, start value and result take effect, and those registers read with bits 31..16 at zero.
- R6: With control bit 1 set, each input byte is bit-reversed before it is folded in.
- R7: With control bit 2 set and raw read-out off, the result is bit-reversed over the active width.
- R8: With control bit 3 set and raw read-out off, the result is XORed with all ones over the active width. With the reset settings plus this bit, "123456789" gives 0xD64E in 16-bit mode and 0xFC891918 in 32-bit mode (polynomial 0x04C11DB7, start 0xFFFFFFFF).
- R9: With control bit 4 set, the result is the raw remainder, with neither reversal nor inversion applied. Writing that value back as the start value resumes the same checksum.
- R10: With polynomial 0x04C11DB7, start value 0xFFFFFFFF and control 0x0F, "123456789" gives 0xCBF43926.
- R11: `wr_ready` is low while bytes are pending. A write held in that window is taken on the first edge after the last byte is folded, and it takes effect after that folding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host offers a register write |
| wr_ready | output | 1 | Engine can take a write this cycle |
| wr_addr | input | 2 | Write address (0 control, 1 polynomial, 2 start value, 3 data) |
| wr_data | input | 32 | Write value; for data, bytes in the low end |
| wr_nbytes | input | 2 | Data write byte count minus one |
| rd_addr | input | 2 | Read address (3 returns the result) |
| rd_data | output | 32 | Combinational read value |
| busy | output | 1 | Bytes still being folded; the result is not final |

## Verification
The interaction to watch is a data write still being folded while the host already offers the next write, here a new start value. The bench presents that start value on the cycle right after a four-byte data write is taken. It counts the cycles `wr_ready` stays low, which must be exactly four. It then confirms that the start value landed after the folding, because the result read afterwards equals the start value. A raw read-out that is fed back as a start value, and a message split across different byte counts, are both compared against an independent bit-serial model.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int unsigned CRC_W = 32;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_POLY = 2'd1,
    A_SEED = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  // Field order matches the control bit positions 4..0.
  typedef struct packed {
    logic raw;
    logic cpl;
    logic rout;
    logic rin;
    logic wide;
  } ctrl_t;

  function automatic logic [CRC_W-1:0] width_mask(input logic wide);
    return wide ? {CRC_W{1'b1}} : {{(CRC_W/2){1'b0}}, {(CRC_W/2){1'b1}}};
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  // Bit-reverse over the active width; the inactive upper half returns zero.
  function automatic logic [CRC_W-1:0] rev_active(input logic [CRC_W-1:0] v, input logic wide);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return wide ? r : (r >> (CRC_W/2));
  endfunction

endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int unsigned W = crc_pkg::CRC_W
) (
  input  logic [W-1:0] rem_i,
  input  logic [7:0]   byte_i,
  input  logic [W-1:0] poly_i,
  input  logic         wide_i,
  output logic [W-1:0] rem_o
);
  localparam int unsigned HALF = W / 2;

  logic [W-1:0] mask;
  logic [W-1:0] stage [0:8];

  assign mask     = wide_i ? {W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign stage[0] = rem_i;

  // One shift-and-conditional-xor per input bit, message bit 7 first.
  for (genvar g = 0; g < 8; g++) begin : g_bit
    logic fb;
    assign fb           = (wide_i ? stage[g][W-1] : stage[g][HALF-1]) ^ byte_i[7-g];
    assign stage[g+1]   = ((stage[g] << 1) & mask) ^ (fb ? poly_i : {W{1'b0}});
  end

  assign rem_o = stage[8];
endmodule

// File: rtl/crc_feeder.sv
module crc_feeder #(
  parameter int unsigned DATA_W = crc_pkg::CRC_W,
  localparam int unsigned NB    = DATA_W / 8,
  localparam int unsigned NBW   = $clog2(NB),
  localparam int unsigned CW    = $clog2(NB + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic [NBW-1:0]    nbytes_i,
  output logic [7:0]        byte_o,
  output logic              busy_o
);
  logic [DATA_W-1:0] buf_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      // Left-align so the most significant valid byte sits at the head.
      buf_q <= word_i << (8 * (int'(NB) - 1 - int'(nbytes_i)));
      cnt_q <= CW'(nbytes_i) + CW'(1);
    end else if (cnt_q != '0) begin
      buf_q <= buf_q << 8;
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign byte_o = buf_q[DATA_W-1 -: 8];
  assign busy_o = (cnt_q != '0);

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_load_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (cnt_q == '0));
endmodule

// File: rtl/crc_out_fmt.sv
module crc_out_fmt #(
  parameter int unsigned W = crc_pkg::CRC_W
) (
  input  logic [W-1:0]   rem_i,
  input  crc_pkg::ctrl_t ctrl_i,
  output logic [W-1:0]   res_o
);
  import crc_pkg::*;

  logic [W-1:0] mask;
  logic [W-1:0] act;
  logic [W-1:0] turned;

  always_comb begin
    mask   = width_mask(ctrl_i.wide);
    act    = rem_i & mask;
    turned = ctrl_i.rout ? rev_active(act, ctrl_i.wide) : act;
    if (ctrl_i.raw) res_o = act;
    else            res_o = ctrl_i.cpl ? (turned ^ mask) : turned;
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine #(
  parameter int unsigned DATA_W = crc_pkg::CRC_W,
  parameter int unsigned ADDR_W = 2,
  localparam int unsigned NBW   = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NBW-1:0]    wr_nbytes,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);
  import crc_pkg::*;

  localparam logic [DATA_W-1:0] POLY_RST = DATA_W'(32'h0000_1021);
  localparam logic [DATA_W-1:0] SEED_RST = DATA_W'(32'h0000_FFFF);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] poly_q, seed_q, rem_q;
  logic [DATA_W-1:0] mask, step_rem, result;
  logic [7:0]        head_byte, fold_byte;
  logic              take, take_seed, take_data;

  assign mask      = width_mask(ctrl_q.wide);
  assign wr_ready  = !busy;
  assign take      = wr_valid && wr_ready;
  assign take_seed = take && (wr_addr == A_SEED);
  assign take_data = take && (wr_addr == A_DATA);

  crc_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (take_data),
    .word_i   (wr_data),
    .nbytes_i (wr_nbytes),
    .byte_o   (head_byte),
    .busy_o   (busy)
  );

  assign fold_byte = ctrl_q.rin ? rev8(head_byte) : head_byte;

  crc_byte_step #(.W(DATA_W)) u_step (
    .rem_i  (rem_q),
    .byte_i (fold_byte),
    .poly_i (poly_q & mask),
    .wide_i (ctrl_q.wide),
    .rem_o  (step_rem)
  );

  crc_out_fmt #(.W(DATA_W)) u_fmt (
    .rem_i  (rem_q),
    .ctrl_i (ctrl_q),
    .res_o  (result)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      poly_q <= POLY_RST;
      seed_q <= SEED_RST;
      rem_q  <= SEED_RST;
    end else begin
      if (take && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[4:0]);
      if (take && wr_addr == A_POLY) poly_q <= wr_data;
      if (take_seed) begin
        seed_q <= wr_data;
        rem_q  <= wr_data & mask;
      end else if (busy) begin
        rem_q  <= step_rem;
      end
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CTRL:  rd_data = {{(DATA_W-5){1'b0}}, ctrl_q};
      A_POLY:  rd_data = poly_q & mask;
      A_SEED:  rd_data = seed_q & mask;
      default: rd_data = result;
    endcase
  end

  assert_seed_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_seed |=> (rem_q == ($past(wr_data) & $past(mask))));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take_seed) |=> (rem_q == $past(rem_q)));

  assert_data_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_data |=> (busy && !wr_ready));

  assert_narrow_upper_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.wide |-> (rd_data[DATA_W-1:DATA_W/2] == '0));
endmodule

// File: tb/crc_engine_bench.sv
module crc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  wr_nbytes = 2'd0;
  logic [1:0]  rd_addr = 2'd0;
  logic [31:0] rd_data;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] msg [0:15];

  always #4 clk = ~clk;

  crc_engine u_crc_engine (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_nbytes(wr_nbytes),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
  );

  // Bit-serial reference over msg[start .. start+n-1].
  function automatic logic [31:0] model(input int start, input int n, input logic [4:0] c,
                                        input logic [31:0] poly, input logic [31:0] seed);
    int w = c[0] ? 32 : 16;
    logic [31:0] m = c[0] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    logic [31:0] r = seed & m;
    logic [31:0] t;
    logic [7:0]  b;
    logic        fb;
    for (int k = start; k < start + n; k++) begin
      b = msg[k];
      if (c[1]) for (int i = 0; i < 8; i++) t[i] = msg[k][7-i];
      if (c[1]) b = t[7:0];
      for (int i = 7; i >= 0; i--) begin
        fb = r[w-1] ^ b[i];
        r  = (r << 1) & m;
        if (fb) r = r ^ (poly & m);
      end
    end
    if (c[4]) return r;
    if (c[2]) begin
      t = '0;
      for (int i = 0; i < w; i++) t[i] = r[w-1-i];
      r = t;
    end
    if (c[3]) r = r ^ m;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [1:0] nb);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_nbytes = nb;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic feed(input int start, input int n, input int chunk);
    int k = start;
    while (k < start + n) begin
      int c = (start + n - k < chunk) ? (start + n - k) : chunk;
      logic [31:0] wd = '0;
      for (int j = 0; j < c; j++) wd = (wd << 8) | 32'(msg[k+j]);
      wr(2'd3, wd, 2'(c - 1));
      k += c;
    end
  endtask

  task automatic setup(input logic [4:0] c, input logic [31:0] p, input logic [31:0] s);
    wr(2'd0, 32'(c), 2'd0);
    wr(2'd1, p, 2'd0);
    wr(2'd2, s, 2'd0);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 32'h0);
    rd(2'd1, v); check("R1 poly", v, 32'h1021);
    rd(2'd2, v); check("R1 seed", v, 32'hFFFF);
    rd(2'd3, v); check("R1 result", v, 32'hFFFF);
  endtask

  task automatic t_default;
    logic [31:0] v;
    wr(2'd2, 32'hFFFF, 2'd0);
    feed(0, 9, 1); rd(2'd3, v);
    check("R2 ccitt bytewise", v, 32'h29B1);
    check("R2 model agrees", model(0, 9, 5'h00, 32'h1021, 32'hFFFF), 32'h29B1);
  endtask

  task automatic t_chunks;
    logic [31:0] v;
    wr(2'd2, 32'hFFFF, 2'd0); feed(0, 9, 4); rd(2'd3, v);
    check("R4 chunks of 4", v, 32'h29B1);
    wr(2'd2, 32'hFFFF, 2'd0); feed(0, 9, 3); rd(2'd3, v);
    check("R4 chunks of 3", v, 32'h29B1);
    wr(2'd2, 32'hFFFF, 2'd0); feed(0, 2, 2); rd(2'd3, v);
    check("R4 msb first", v, model(0, 2, 5'h00, 32'h1021, 32'hFFFF));
  endtask

  task automatic t_seed;
    logic [31:0] v;
    wr(2'd2, 32'h1D0F, 2'd0); rd(2'd3, v);
    check("R3 seed visible", v, 32'h1D0F);
    repeat (3) @(negedge clk);
    rd(2'd3, v); check("R3 idle hold", v, 32'h1D0F);
    feed(0, 9, 4); rd(2'd3, v);
    check("R3 fresh start", v, model(0, 9, 5'h00, 32'h1021, 32'h1D0F));
  endtask

  task automatic t_width;
    logic [31:0] v;
    setup(5'h00, 32'hABCD_1021, 32'h1234_FFFF);
    rd(2'd1, v); check("R5 poly narrow", v, 32'h1021);
    rd(2'd2, v); check("R5 seed narrow", v, 32'hFFFF);
    feed(0, 9, 4); rd(2'd3, v); check("R5 upper poly ignored", v, 32'h29B1);
    wr(2'd0, 32'h01, 2'd0);
    rd(2'd1, v); check("R5 poly wide", v, 32'hABCD_1021);
  endtask

  task automatic t_flags;
    logic [31:0] v;
    setup(5'h02, 32'h1021, 32'hFFFF); feed(0, 9, 4); rd(2'd3, v);
    check("R6 reflect in", v, model(0, 9, 5'h02, 32'h1021, 32'hFFFF));
    setup(5'h04, 32'h1021, 32'hFFFF); feed(0, 9, 4); rd(2'd3, v);
    check("R7 reflect out", v, model(0, 9, 5'h04, 32'h1021, 32'hFFFF));
    setup(5'h05, 32'h04C11DB7, 32'h0); feed(0, 9, 4); rd(2'd3, v);
    check("R7 reflect out 32", v, model(0, 9, 5'h05, 32'h04C11DB7, 32'h0));
    setup(5'h08, 32'h1021, 32'hFFFF); feed(0, 9, 4); rd(2'd3, v);
    check("R8 complement 16", v, 32'hD64E);
    setup(5'h09, 32'h04C11DB7, 32'hFFFF_FFFF); feed(0, 9, 4); rd(2'd3, v);
    check("R8 complement 32", v, 32'hFC89_1918);
  endtask

  task automatic t_crc32;
    logic [31:0] v;
    setup(5'h0F, 32'h04C11DB7, 32'hFFFF_FFFF); feed(0, 9, 4); rd(2'd3, v);
    check("R10 reflected crc32", v, 32'hCBF4_3926);
    check("R10 model agrees", model(0, 9, 5'h0F, 32'h04C11DB7, 32'hFFFF_FFFF), 32'hCBF4_3926);
  endtask

  task automatic t_resume;
    logic [31:0] mid, v;
    setup(5'h1F, 32'h04C11DB7, 32'hFFFF_FFFF); feed(0, 5, 2); rd(2'd3, mid);
    check("R9 raw readout", mid, model(0, 5, 5'h1F, 32'h04C11DB7, 32'hFFFF_FFFF));
    wr(2'd0, 32'h0F, 2'd0);
    wr(2'd2, mid, 2'd0);
    feed(5, 4, 4); rd(2'd3, v);
    check("R9 resume from raw", v, 32'hCBF4_3926);
  endtask

  task automatic t_backpressure;
    logic [31:0] v;
    int low = 0;
    setup(5'h00, 32'h1021, 32'hFFFF);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 2'd3; wr_data = 32'h3132_3334; wr_nbytes = 2'd3;
    @(negedge clk);
    wr_addr = 2'd2; wr_data = 32'h0000_BEEF; wr_nbytes = 2'd0;
    while (!wr_ready) begin low++; @(negedge clk); end
    @(negedge clk);
    wr_valid = 1'b0;
    check("R11 stall cycles", 32'(low), 32'd4);
    rd(2'd3, v); check("R11 held write lands after fold", v, 32'hBEEF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) msg[i] = 8'h31 + 8'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_default;
    t_chunks;
    t_seed;
    t_width;
    t_flags;
    t_crc32;
    t_resume;
    t_backpressure;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule